// File: doc/BRIEF.md
# Posted Write Buffer with Read Forwarding

This block sits between a CPU and an external memory controller and posts CPU writes into a small in-order queue. A write is taken in the cycle it is offered while a slot is free, so the CPU does not wait for the external bus. Whenever no other bus master holds the external bus, the oldest queued write is offered to the memory controller with a valid/ready handshake. One entry leaves per completed handshake.

Every queued entry keeps its full 27-bit address tag beside its data. A CPU read is first compared against all pending entries. On a match the newest matching data is returned in the same cycle and no memory read is issued. On a miss the read is passed on to memory, and the queued writes are left as they are. When all slots are occupied the CPU is stalled. A write offered in a cycle where the head entry drains is still accepted.

Top module: `wbuf_fwd`

## Requirements
- R1: After reset the buffer is empty: `mem_wr_valid_o` is 0, `cpu_wr_ready_o` is 1, `cpu_stall_o` is 0 and `cpu_rd_hit_o` is 0.
- R2: While fewer than four entries are pending, `cpu_wr_ready_o` is 1 whatever `bus_busy_i` is. A write with `cpu_wr_valid_i`=1 is stored at the next rising edge.
- R3: `mem_wr_valid_o` is 1 exactly when at least one entry is pending and `bus_busy_i` is 0.
- R4: Entries leave in the order they were written. Exactly one entry is removed per cycle with `mem_wr_valid_o`=1 and `mem_wr_ready_i`=1, and `mem_wr_addr_o`/`mem_wr_data_o` show the oldest entry.
- R5: The buffer holds at most four entries. With four pending and no drain in the cycle, `cpu_wr_ready_o` is 0, and `cpu_stall_o` is 1 while `cpu_wr_valid_i` is 1. The offered write is not stored.
- R6: With four entries pending, a write offered in a cycle that completes a drain handshake is accepted (`cpu_wr_ready_o`=1). The count stays at four and no entry is lost.
- R7: A CPU read whose address equals a pending entry's tag gives `cpu_rd_hit_o`=1 and that entry's data on `cpu_rd_data_o` in the same cycle, with `mem_rd_valid_o`=0.
- R8: When several pending entries match a read, the most recently written of them supplies `cpu_rd_data_o`.
- R9: A read that matches no pending entry gives `cpu_rd_hit_o`=0 and `mem_rd_valid_o`=1 with `mem_rd_addr_o` equal to the read address. Pending writes and their order are not changed.
- R10: The match compares all 27 address bits. Addresses that differ only in bit 26 do not match.
- R11: While `mem_wr_valid_o` is 1 and `mem_wr_ready_i` is 0, the offered address and data stay stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_wr_valid_i | input | 1 | CPU offers a write |
| cpu_wr_addr_i | input | 27 | Write address |
| cpu_wr_data_i | input | 32 | Write data |
| cpu_wr_ready_o | output | 1 | Write is accepted this cycle |
| cpu_stall_o | output | 1 | CPU write held, buffer full |
| cpu_rd_valid_i | input | 1 | CPU issues a read |
| cpu_rd_addr_i | input | 27 | Read address |
| cpu_rd_hit_o | output | 1 | Read matched a pending entry |
| cpu_rd_data_o | output | 32 | Forwarded data (0 on miss) |
| mem_rd_valid_o | output | 1 | Missed read passed to memory |
| mem_rd_addr_o | output | 27 | Address of the passed read |
| bus_busy_i | input | 1 | External bus held by another master |
| mem_wr_valid_o | output | 1 | Oldest entry offered to memory |
| mem_wr_addr_o | output | 27 | Offered write address |
| mem_wr_data_o | output | 32 | Offered write data |
| mem_wr_ready_i | input | 1 | Memory controller takes the offered write |

## Verification
Bursts of writes arrive while the bus is held busy, then the bus frees with the memory ready signal held low. This separates the stall on a full buffer from the drain gating and the hold of the offered data. A full buffer is then written in the same cycle as a drain, which exposes a lost entry or a wrongly rejected write. Reads use repeated addresses, aliases that differ only in the top bit, and cold addresses, which separate newest-wins forwarding from oldest-wins forwarding, partial tag compares and misses. A long random phase with toggling bus, ready, write and read mixes these cases in every order against a queue model.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  parameter int unsigned ADDR_W = 27;
  parameter int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  wb_entry_t             push_entry_i,
  input  logic                  pop_i,
  output wb_entry_t             head_o,
  output wb_entry_t [DEPTH-1:0] slots_o,
  output logic [PTR_W-1:0]      head_ptr_o,
  output logic [CNT_W-1:0]      count_o,
  output logic                  full_o,
  output logic                  empty_o
);
  wb_entry_t [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      mem_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= push_entry_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o     = mem_q[rd_q];
  assign slots_o    = mem_q;
  assign head_ptr_o = rd_q;
  assign count_o    = cnt_q;
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R5
  AST_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i)); // R6
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R4
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  wb_entry_t [DEPTH-1:0] slots_i,
  input  logic [PTR_W-1:0]      head_ptr_i,
  input  logic [CNT_W-1:0]      count_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  hit_o,
  output logic [DATA_W-1:0]     data_o
);
  // walk oldest to newest; a later match overrides an earlier one
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int unsigned age = 0; age < DEPTH; age++) begin
      int unsigned idx;
      idx = int'(head_ptr_i) + age;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if ((age < int'(count_i)) && (slots_i[idx].addr == addr_i)) begin
        hit_o  = 1'b1;
        data_o = slots_i[idx].data;
      end
    end
  end
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_valid_i,
  input  logic [ADDR_W-1:0] cpu_wr_addr_i,
  input  logic [DATA_W-1:0] cpu_wr_data_i,
  output logic              cpu_wr_ready_o,
  output logic              cpu_stall_o,
  input  logic              cpu_rd_valid_i,
  input  logic [ADDR_W-1:0] cpu_rd_addr_i,
  output logic              cpu_rd_hit_o,
  output logic [DATA_W-1:0] cpu_rd_data_o,
  output logic              mem_rd_valid_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              bus_busy_i,
  output logic              mem_wr_valid_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i
);
  wb_entry_t             head, push_entry;
  wb_entry_t [DEPTH-1:0] slots;
  logic [PTR_W-1:0]      head_ptr;
  logic [CNT_W-1:0]      count;
  logic                  full, empty, push, pop, hit;
  logic [DATA_W-1:0]     fwd_data;

  assign mem_wr_valid_o = !empty && !bus_busy_i;
  assign pop            = mem_wr_valid_o && mem_wr_ready_i;
  // a drain in the same cycle frees the slot the write needs
  assign cpu_wr_ready_o = !full || pop;
  assign push           = cpu_wr_valid_i && cpu_wr_ready_o;
  assign cpu_stall_o    = cpu_wr_valid_i && !cpu_wr_ready_o;
  assign push_entry     = '{addr: cpu_wr_addr_i, data: cpu_wr_data_i};

  wbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (push_entry),
    .pop_i        (pop),
    .head_o       (head),
    .slots_o      (slots),
    .head_ptr_o   (head_ptr),
    .count_o      (count),
    .full_o       (full),
    .empty_o      (empty)
  );

  wbuf_match #(.DEPTH(DEPTH)) u_match (
    .slots_i    (slots),
    .head_ptr_i (head_ptr),
    .count_i    (count),
    .addr_i     (cpu_rd_addr_i),
    .hit_o      (hit),
    .data_o     (fwd_data)
  );

  assign mem_wr_addr_o  = head.addr;
  assign mem_wr_data_o  = head.data;
  assign cpu_rd_hit_o   = cpu_rd_valid_i && hit;
  assign cpu_rd_data_o  = cpu_rd_hit_o ? fwd_data : '0;
  assign mem_rd_valid_o = cpu_rd_valid_i && !hit;
  assign mem_rd_addr_o  = cpu_rd_addr_i;

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      ($stable(mem_wr_addr_o) && $stable(mem_wr_data_o))); // R11
  AST_HIT_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_hit_o |-> !empty); // R7
  AST_STALL_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> (count == CNT_W'(DEPTH))); // R5
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop && !full) |=> (count == $past(count) + 1'b1)); // R2
endmodule

// File: tb/tb_wbuf_fwd.sv
module tb_wbuf_fwd;
  logic        clk = 0, rst_n = 0;
  logic        wv = 0, rv = 0, busy = 1, mrdy = 0;
  logic [26:0] wa = 0, ra = 0;
  logic [31:0] wd = 0;
  logic        wr_rdy, stall, hit, mrv, mwv;
  logic [31:0] rdat, mwd;
  logic [26:0] mra, mwa;
  int checks = 0, fails = 0;
  logic [26:0] qa[$];
  logic [31:0] qd[$];

  always #2 clk = ~clk;

  wbuf_fwd dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_wr_valid_i(wv), .cpu_wr_addr_i(wa), .cpu_wr_data_i(wd),
    .cpu_wr_ready_o(wr_rdy), .cpu_stall_o(stall),
    .cpu_rd_valid_i(rv), .cpu_rd_addr_i(ra),
    .cpu_rd_hit_o(hit), .cpu_rd_data_o(rdat),
    .mem_rd_valid_o(mrv), .mem_rd_addr_o(mra),
    .bus_busy_i(busy), .mem_wr_valid_o(mwv),
    .mem_wr_addr_o(mwa), .mem_wr_data_o(mwd), .mem_wr_ready_i(mrdy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare against the queue model, update model at posedge
  task automatic cyc(input logic w, input logic [26:0] a, input logic [31:0] d,
                     input logic r, input logic [26:0] b,
                     input logic bz, input logic rdy);
    logic e_mwv, e_rdy, e_hit, e_push, e_pop;
    logic [31:0] e_dat;
    wv = w; wa = a; wd = d; rv = r; ra = b; busy = bz; mrdy = rdy;
    #1;
    e_mwv = (qa.size() > 0) && !bz;
    e_pop = e_mwv && rdy;
    e_rdy = (qa.size() < 4) || e_pop;
    e_push = w && e_rdy;
    e_hit = 0; e_dat = 0;
    foreach (qa[i]) if (r && qa[i] == b) begin e_hit = 1; e_dat = qd[i]; end
    chk("R3 mem_wr_valid", 64'(mwv), 64'(e_mwv));
    if (e_mwv) begin
      chk("R4 head addr", 64'(mwa), 64'(qa[0]));
      chk("R4 head data", 64'(mwd), 64'(qd[0]));
    end
    chk((qa.size() == 4) ? "R6 ready when full" : "R2 ready", 64'(wr_rdy), 64'(e_rdy));
    chk("R5 stall", 64'(stall), 64'(w && !e_rdy));
    chk("R7 hit", 64'(hit), 64'(e_hit));
    if (e_hit) chk("R8 forwarded data", 64'(rdat), 64'(e_dat));
    chk("R9 mem read valid", 64'(mrv), 64'(r && !e_hit));
    if (r && !e_hit) chk("R9 mem read addr", 64'(mra), 64'(b));
    @(posedge clk);
    if (e_pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
    if (e_push) begin qa.push_back(a); qd.push_back(d); end
    @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    busy = 0;
    #1;
    chk("R1 reset mem_wr_valid", 64'(mwv), 0);
    chk("R1 reset ready", 64'(wr_rdy), 1);
    chk("R1 reset stall", 64'(stall), 0);
    rst_n = 1;
    @(negedge clk);
    // R2/R5: fill with bus busy, then a stalled fifth write
    for (int i = 0; i < 4; i++) cyc(1, 27'h100 + 27'(i), 32'hA0 + i, 0, 0, 1, 1);
    cyc(1, 27'h1FF, 32'hDEAD, 0, 0, 1, 1);
    chk("R5 count held at four", 64'(qa.size()), 4);
    // R8: newest of duplicates, R10: bit 26 alias
    cyc(0, 0, 0, 0, 0, 1, 0);
    // R11: bus free, memory not ready
    cyc(0, 0, 0, 1, 27'h4000101, 0, 0);
    cyc(0, 0, 0, 1, 27'h101, 0, 0);
    // R6: write while full during a drain
    cyc(1, 27'h101, 32'hBEEF, 0, 0, 0, 1);
    chk("R6 no entry lost", 64'(qa.size()), 4);
    cyc(0, 0, 0, 1, 27'h101, 1, 0);
    chk("R8 newest wins", 64'(rdat), 32'hBEEF);
    cyc(0, 0, 0, 1, 27'h4000101, 1, 0);
    chk("R10 bit26 alias misses", 64'(hit), 0);
    cyc(0, 0, 0, 1, 27'h777, 1, 0);
    chk("R9 pending unchanged", 64'(qa.size()), 4);
    // R4: drain everything in order
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    // mixed random phase
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 1) == 1, 27'($urandom_range(0, 7)) | {($urandom_range(0, 3) == 0), 26'h0},
          $urandom, $urandom_range(0, 1) == 1, 27'($urandom_range(0, 9)),
          $urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule